// File: doc/BRIEF.md
# Page Address Translation Unit

This block widens a 16-bit logical CPU address into a 20-bit physical address. The logical space is split into sixteen 4 KB pages. The top four logical address bits pick one of sixteen table entries. Each 8-bit entry supplies the four physical page bits and four extended physical bits, and the 12-bit offset inside the page passes through unchanged. The page field of each entry is held in complemented form, and the lookup complements it again on the way out.

The CPU fills the table by storing bytes into the last sixteen addresses of its logical space. A store to the address ending in k loads entry k. From reset the table holds an identity mapping, so code in the top page can run before software writes the table. A second lookup port translates any logical address with no bus cycle, so software can ask where a logical address really lands in physical memory.

Top module: `page_xlate_unit`

## Requirements
- R1: The entry used for a translation is selected by logical address bits 15:12, and physical bits 15:12 equal the bitwise complement of bits 3:0 of that entry.
- R2: When `cpu_wr` is high at a rising clock edge and `cpu_addr` is in 0xFFF0..0xFFFF, entry `cpu_addr[3:0]` takes `cpu_wdata`. The new mapping is visible at the outputs from the next cycle.
- R3: Physical bits 11:0 always equal logical bits 11:0, on both lookup ports.
- R4: A store whose address lies outside 0xFFF0..0xFFFF does not change any table entry. A cycle with `cpu_wr` low also leaves every entry unchanged.
- R5: Physical bits 19:16 equal bits 7:4 of the selected entry.
- R6: After reset every entry i holds 8'h0 in bits 7:4 and the complement of i in bits 3:0. Every logical address therefore maps to the same value, zero-extended to 20 bits.
- R7: `probe_phys` is the combinational translation of `probe_addr` through the same table, independent of `cpu_addr`. When the two addresses are equal, the two outputs are equal.
- R8: Loading 0x0F, 0x0E, ... 0x01 into entries 0 to 14 gives an identity mapping for pages 0 to 14. Loading 0xF0 into entry 15 maps logical page 0xF to physical 0xFF000 plus the offset.
- R9: During the cycle in which a table store is presented, `phys_addr` still shows the translation through the entry's previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; table writes occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; loads the identity table |
| cpu_addr | input | 16 | Logical CPU address, both for translation and for table stores |
| cpu_wr | input | 1 | CPU store strobe |
| cpu_wdata | input | 8 | Store data; an entry value when the address hits the table window |
| phys_addr | output | 20 | Physical translation of `cpu_addr` |
| probe_addr | input | 16 | Logical address for the side lookup |
| probe_phys | output | 20 | Physical translation of `probe_addr` |

## Verification
A corrupted entry appears at once as a wrong page or wrong extension nibble. It shows on any lookup whose top four bits select that entry, on either port, in the same cycle. A store decoded to the wrong index, or to an address outside the window, stays hidden until that page is looked up. For this reason the directed scenarios sweep all sixteen pages after every change to the table. A one-cycle timing slip in the write path shows as the new value already present during the store cycle, or as the new value still missing one cycle later.

// File: rtl/ptu_pkg.sv
package ptu_pkg;

   // How the page-number field is held inside a table entry
   typedef enum logic [0:0] {
      POL_TRUE     = 1'b0,
      POL_INVERTED = 1'b1
   } store_pol_e;

   localparam int unsigned DEF_LA_W      = 16;
   localparam int unsigned DEF_PAGE_BITS = 4;
   localparam int unsigned DEF_EXT_BITS  = 4;

endpackage

// File: rtl/ptu_window_decode.sv
module ptu_window_decode #(
   parameter int unsigned LA_W      = ptu_pkg::DEF_LA_W,
   parameter int unsigned PAGE_BITS = ptu_pkg::DEF_PAGE_BITS
) (
   input  logic [LA_W-1:0]      addr,
   input  logic                 wr,
   output logic                 hit,
   output logic [PAGE_BITS-1:0] idx
);
   localparam int unsigned TAG_W = LA_W - PAGE_BITS;

   if (PAGE_BITS >= LA_W) begin : g_bad_split
      $error("window decode: PAGE_BITS must be below LA_W");
   end

   // The window is the last 2**PAGE_BITS logical addresses
   always_comb begin
      hit = wr && (addr[LA_W-1:PAGE_BITS] == {TAG_W{1'b1}});
      idx = addr[PAGE_BITS-1:0];
   end
endmodule

// File: rtl/ptu_map_table.sv
module ptu_map_table
   import ptu_pkg::*;
#(
   parameter int unsigned PAGE_BITS = ptu_pkg::DEF_PAGE_BITS,
   parameter int unsigned EXT_BITS  = ptu_pkg::DEF_EXT_BITS,
   parameter store_pol_e  POL       = POL_INVERTED
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [PAGE_BITS-1:0]              wr_idx,
   input  logic [PAGE_BITS+EXT_BITS-1:0]     wr_data,
   output logic [(2**PAGE_BITS)*(PAGE_BITS+EXT_BITS)-1:0] entries_flat
);
   localparam int unsigned EW = PAGE_BITS + EXT_BITS;
   localparam int unsigned N  = 2 ** PAGE_BITS;

   if (N > 256) begin : g_bad_depth
      $error("map table: too many entries for a register table");
   end

   logic [EW-1:0] ent_q [N];

   for (genvar i = 0; i < N; i++) begin : g_ent
      localparam logic [PAGE_BITS-1:0] PG    = PAGE_BITS'(i);
      localparam logic [PAGE_BITS-1:0] PG_ST = (POL == POL_INVERTED) ? ~PG : PG;
      localparam logic [EW-1:0]        RST_V = {{EXT_BITS{1'b0}}, PG_ST};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q[i] <= RST_V;
         end else if (wr_en && (wr_idx == PG)) begin
            ent_q[i] <= wr_data;
         end
      end

      assign entries_flat[i*EW +: EW] = ent_q[i];

      // R2: a decoded store lands in exactly this entry
      p_store_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && (wr_idx == PG)) |=> (ent_q[i] == $past(wr_data)));

      // R6: first active cycle sees the identity value
      p_reset_ident_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rst_n) |-> (ent_q[i] == RST_V));
   end

   // R4: without a decoded store the table does not move
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(entries_flat));
endmodule

// File: rtl/ptu_lookup.sv
module ptu_lookup
   import ptu_pkg::*;
#(
   parameter int unsigned LA_W      = ptu_pkg::DEF_LA_W,
   parameter int unsigned PAGE_BITS = ptu_pkg::DEF_PAGE_BITS,
   parameter int unsigned EXT_BITS  = ptu_pkg::DEF_EXT_BITS,
   parameter store_pol_e  POL       = POL_INVERTED
) (
   input  logic [(2**PAGE_BITS)*(PAGE_BITS+EXT_BITS)-1:0] entries_flat,
   input  logic [LA_W-1:0]          laddr,
   output logic [LA_W+EXT_BITS-1:0] paddr
);
   localparam int unsigned EW    = PAGE_BITS + EXT_BITS;
   localparam int unsigned OFF_W = LA_W - PAGE_BITS;

   logic [PAGE_BITS-1:0] sel;
   logic [EW-1:0]        ent;
   logic [PAGE_BITS-1:0] page;
   logic [EXT_BITS-1:0]  ext;

   assign sel = laddr[LA_W-1 -: PAGE_BITS];
   assign ent = entries_flat[sel*EW +: EW];
   assign ext = ent[EW-1 -: EXT_BITS];

   if (POL == POL_INVERTED) begin : g_inv
      assign page = ~ent[PAGE_BITS-1:0];
   end else begin : g_true
      assign page = ent[PAGE_BITS-1:0];
   end

   assign paddr = {ext, page, laddr[OFF_W-1:0]};
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
   import ptu_pkg::*;
#(
   parameter int unsigned LA_W      = ptu_pkg::DEF_LA_W,
   parameter int unsigned PAGE_BITS = ptu_pkg::DEF_PAGE_BITS,
   parameter int unsigned EXT_BITS  = ptu_pkg::DEF_EXT_BITS,
   parameter int unsigned DATA_W    = 8,
   parameter store_pol_e  POL       = POL_INVERTED
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [LA_W-1:0]          cpu_addr,
   input  logic                     cpu_wr,
   input  logic [DATA_W-1:0]        cpu_wdata,
   output logic [LA_W+EXT_BITS-1:0] phys_addr,
   input  logic [LA_W-1:0]          probe_addr,
   output logic [LA_W+EXT_BITS-1:0] probe_phys
);
   localparam int unsigned EW = PAGE_BITS + EXT_BITS;
   localparam int unsigned N  = 2 ** PAGE_BITS;

   if (DATA_W != EW) begin : g_bad_entry
      $error("translation unit: DATA_W must equal PAGE_BITS + EXT_BITS");
   end

   logic                 wr_hit;
   logic [PAGE_BITS-1:0] wr_idx;
   logic [N*EW-1:0]      entries_flat;

   ptu_window_decode #(
      .LA_W      (LA_W),
      .PAGE_BITS (PAGE_BITS)
   ) u_dec (
      .addr (cpu_addr),
      .wr   (cpu_wr),
      .hit  (wr_hit),
      .idx  (wr_idx)
   );

   ptu_map_table #(
      .PAGE_BITS (PAGE_BITS),
      .EXT_BITS  (EXT_BITS),
      .POL       (POL)
   ) u_tbl (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_hit),
      .wr_idx       (wr_idx),
      .wr_data      (cpu_wdata),
      .entries_flat (entries_flat)
   );

   ptu_lookup #(
      .LA_W      (LA_W),
      .PAGE_BITS (PAGE_BITS),
      .EXT_BITS  (EXT_BITS),
      .POL       (POL)
   ) u_cpu_lk (
      .entries_flat (entries_flat),
      .laddr        (cpu_addr),
      .paddr        (phys_addr)
   );

   ptu_lookup #(
      .LA_W      (LA_W),
      .PAGE_BITS (PAGE_BITS),
      .EXT_BITS  (EXT_BITS),
      .POL       (POL)
   ) u_probe_lk (
      .entries_flat (entries_flat),
      .laddr        (probe_addr),
      .paddr        (probe_phys)
   );

   // R7: the two lookup paths agree on equal inputs
   p_probe_agree_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_addr == cpu_addr) |-> (probe_phys == phys_addr));

   // R9: the stored entry changes only after the store edge, so the
   // translation seen during a store cycle follows the old table
   p_store_cycle_old_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && (cpu_addr == $past(cpu_addr)) && $stable(entries_flat))
         |-> (phys_addr == $past(phys_addr)));
endmodule

// File: tb/tb_page_xlate_unit.sv
`timescale 1ns/1ps
module tb_page_xlate_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0;
   logic        cpu_wr = 1'b0;
   logic [7:0]  cpu_wdata = 8'h0;
   logic [19:0] phys_addr;
   logic [15:0] probe_addr = 16'h0;
   logic [19:0] probe_phys;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [7:0] model [16];

   always #2.5 clk = ~clk;

   page_xlate_unit dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_addr   (cpu_addr),
      .cpu_wr     (cpu_wr),
      .cpu_wdata  (cpu_wdata),
      .phys_addr  (phys_addr),
      .probe_addr (probe_addr),
      .probe_phys (probe_phys)
   );

   function automatic logic [19:0] exp_phys(input logic [15:0] a);
      logic [7:0] e;
      e = model[a[15:12]];
      return {e[7:4], ~e[3:0], a[11:0]};
   endfunction

   task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
      end
   endtask

   // Sweep every page on the CPU port with a given offset
   task automatic sweep_cpu(input string tag, input logic [11:0] off);
      for (int p = 0; p < 16; p++) begin
         @(negedge clk);
         cpu_wr   = 1'b0;
         cpu_addr = {4'(p), off};
         #1;
         check(tag, phys_addr, exp_phys(cpu_addr));
      end
   endtask

   // One store into the window, checking the store cycle and the next
   task automatic store_entry(input logic [3:0] k, input logic [7:0] d);
      @(negedge clk);
      cpu_addr  = {12'hFFF, k};
      cpu_wdata = d;
      cpu_wr    = 1'b1;
      #1;
      check("R9 old mapping in store cycle", phys_addr, exp_phys(cpu_addr));
      @(posedge clk);
      model[k] = d;
      @(negedge clk);
      cpu_wr = 1'b0;
      #1;
      check("R2 store visible next cycle", phys_addr, exp_phys(cpu_addr));
   endtask

   task automatic t_reset_state();
      for (int p = 0; p < 16; p++) model[p] = {4'h0, ~4'(p)};
      sweep_cpu("R6 identity after reset", 12'hA5C);
      sweep_cpu("R6 identity after reset", 12'h000);
      @(negedge clk);
      cpu_addr = 16'h7123; #1;
      check("R6 zero-extended logical", phys_addr, 20'h07123);
   endtask

   task automatic t_custom_map();
      store_entry(4'h3, 8'hA5);
      @(negedge clk); cpu_addr = 16'h3ABC; #1;
      check("R1 R5 page 3 remapped", phys_addr, 20'hAAABC);
      store_entry(4'h0, 8'h3C);
      @(negedge clk); cpu_addr = 16'h0FFF; #1;
      check("R1 R5 page 0 remapped", phys_addr, 20'h33FFF);
      sweep_cpu("R1 sweep after remap", 12'h5A5);
      sweep_cpu("R3 offset passthrough", 12'hFFF);
   endtask

   task automatic t_outside_window();
      logic [15:0] bad [4];
      bad[0] = 16'hFFEF; bad[1] = 16'h3FF0; bad[2] = 16'h7FF3; bad[3] = 16'hEFF5;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         cpu_addr  = bad[i];
         cpu_wdata = 8'h99;
         cpu_wr    = 1'b1;
      end
      @(negedge clk);
      cpu_wr = 1'b0;
      // window address with strobe low must not store either
      cpu_addr = 16'hFFF3; cpu_wdata = 8'h11;
      @(negedge clk);
      sweep_cpu("R4 no store outside window", 12'h321);
   endtask

   task automatic t_probe();
      @(negedge clk);
      cpu_addr   = 16'h0123;
      probe_addr = 16'h3456;
      #1;
      check("R7 probe independent of cpu", probe_phys, exp_phys(16'h3456));
      check("R7 cpu side unaffected", phys_addr, exp_phys(16'h0123));
      for (int p = 0; p < 16; p++) begin
         @(negedge clk);
         probe_addr = {4'(p), 12'hC3A};
         cpu_addr   = 16'h5000;
         #1;
         check("R7 probe sweep", probe_phys, exp_phys(probe_addr));
         check("R3 probe offset", {8'h0, probe_phys[11:0]}, 20'h00C3A);
      end
   endtask

   task automatic t_boot_sequence();
      for (int k = 0; k < 15; k++) store_entry(4'(k), 8'(15 - k));
      store_entry(4'hF, 8'hF0);
      for (int p = 0; p < 15; p++) begin
         @(negedge clk);
         cpu_addr = {4'(p), 12'h8E1};
         #1;
         check("R8 identity pages 0-14", phys_addr, {4'h0, cpu_addr});
      end
      @(negedge clk);
      cpu_addr = 16'hF800; #1;
      check("R8 top page high", phys_addr, 20'hFF800);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_custom_map();
      t_outside_window();
      t_probe();
      t_boot_sequence();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule